// File: doc/BRIEF.md
# Segment Register Table with Identifier-Exchange Remap

This block is the segment stage of a reverse-mapped address translator. A 32-bit virtual address arrives as an 8-bit address-space number followed by a 24-bit offset. The offset splits into a 6-bit segment field, a 7-bit page field and an 11-bit byte offset. The block folds the address-space number and the segment field into a 13-bit global segment number. Segments whose top segment bit is set live in a region shared by every address space. The block then picks one entry of a table of segment registers by bit extraction and compares the stored tag against the global segment number. It returns the entry's short segment identifier together with a hit, collision or permission-fault verdict. The page stage that follows uses that identifier as its hash input.

Operating-system software fills the table through a write port that sets an entry's tag and rights. When a segment changes its virtual address it must move to another slot. The remap command writes the new tag and the old slot's rights into the new slot and swaps the two slots' identifiers. A segment therefore keeps its identifier wherever it is mapped, so page-level entries keyed by that identifier stay valid. No two slots ever share an identifier.

Top module: `segmap_csr_unit`

## Requirements
- R1: The global segment number is {region, low 5 segment bits}. The region is 8'hFF when bit 5 of the segment field (address bit 23) is 1, and is the address-space number (address bits 31:24) otherwise.
- R2: The slot is the low IDX_W bits of the global segment number. When the slot's tag equals the global segment number, the response shows hit=1 and collision=0; otherwise it shows hit=0 and collision=1.
- R3: A request accepted at a clock edge (req_valid=1, rmp_busy=0) yields rsp_valid=1 after that edge. In every other cycle rsp_valid and all verdict outputs are 0.
- R4: The rights bits are bit0 read, bit1 write, bit2 execute and bit3 supervisor-only. On a hit, rsp_perm_fault=1 if the request asks for read, write or execute without the matching bit, or if bit3 is set and req_sup=0. On a hit, rsp_seg_id is the slot's identifier.
- R5: On a collision, rsp_perm_fault=0 whatever the flags are, and rsp_seg_id=0.
- R6: After reset, every slot holds tag 0 and rights 0, and its identifier equals its own slot number. No response is pending and rmp_busy=0.
- R7: An OS write (os_we=1 while not busy) replaces the tag and rights of os_slot and leaves its identifier unchanged.
- R8: A remap from rmp_old_slot to the new global segment number writes that number as the new slot's tag. The new slot is the low IDX_W bits of the new number. The new slot takes the old slot's rights and identifier, and the old slot takes the new slot's former identifier. The old slot keeps its tag and rights.
- R9: A remap accepted while idle holds rmp_busy=1 for exactly two cycles. While busy, lookups, OS writes and further remap commands are ignored, and the table change is visible to the first lookup accepted after busy falls.
- R10: A remap whose new slot equals its old slot replaces the tag and leaves the identifier unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_rd | input | 1 | Request reads |
| req_wr | input | 1 | Request writes |
| req_ex | input | 1 | Request executes |
| req_sup | input | 1 | Requester is in supervisor mode |
| rsp_valid | output | 1 | Lookup result present |
| rsp_hit | output | 1 | Stored tag matched |
| rsp_collision | output | 1 | Stored tag differed |
| rsp_perm_fault | output | 1 | Access rights violated on a hit |
| rsp_seg_id | output | IDX_W | Segment identifier on a hit |
| os_we | input | 1 | Software entry write |
| os_slot | input | IDX_W | Slot to write |
| os_tag | input | 13 | Global segment number tag to store |
| os_perm | input | 4 | Rights to store |
| rmp_start | input | 1 | Begin a remap |
| rmp_old_slot | input | IDX_W | Slot the segment leaves |
| rmp_new_gsn | input | 13 | Global segment number the segment moves to |
| rmp_busy | output | 1 | Remap in progress |

## Verification
The bench uses the default IDX_W=8, so the table has 256 slots and the slot number takes three region bits next to the five segment bits. Address spaces 0x01 and 0x09 then reach the same slot with different tags, which yields a real collision. The shared region lands in slots 0xE0 to 0xFF, where address space 0xFF with a clear top segment bit aliases a folded address. The identifier is as wide as the slot number, so the reset identity of any slot and the swapped values after a remap can be read directly from rsp_seg_id.

// File: rtl/segmap_pkg.sv
package segmap_pkg;

    localparam int VA_W   = 32;
    localparam int ASN_W  = 8;
    localparam int SEG_W  = 6;
    localparam int PAGE_W = 7;
    localparam int BYTE_W = 11;
    localparam int GSN_W  = ASN_W + SEG_W - 1;
    localparam int PERM_W = 4;

    localparam int SEG_LSB = PAGE_W + BYTE_W;
    localparam int ASN_LSB = SEG_LSB + SEG_W;

    localparam logic [ASN_W-1:0] SHARED_REGION = '1;

    // Access rights; the first member is the most significant bit.
    typedef struct packed {
        logic sup;
        logic ex;
        logic wr;
        logic rd;
    } perm_t;

    typedef enum logic [1:0] {
        RM_IDLE  = 2'd0,
        RM_READ  = 2'd1,
        RM_WRITE = 2'd2
    } rm_state_e;

    // Global segment number from address-space number and segment field.
    function automatic logic [GSN_W-1:0] fold_gsn(
        input logic [ASN_W-1:0] asn,
        input logic [SEG_W-1:0] seg
    );
        logic [ASN_W-1:0] region;
        region = seg[SEG_W-1] ? SHARED_REGION : asn;
        return {region, seg[SEG_W-2:0]};
    endfunction

    // True when the request asks for more than the stored rights allow.
    function automatic logic perm_denied(input perm_t have, input perm_t want);
        return (want.rd & ~have.rd) | (want.wr & ~have.wr) |
               (want.ex & ~have.ex) | (have.sup & ~want.sup);
    endfunction

endpackage

// File: rtl/segmap_gsn.sv
module segmap_gsn
    import segmap_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic [ASN_W-1:0] asn,
    input  logic [SEG_W-1:0] seg,
    output logic [GSN_W-1:0] gsn,
    output logic [IDX_W-1:0] idx
);

    always_comb begin
        gsn = fold_gsn(asn, seg);
        idx = gsn[IDX_W-1:0];
    end

endmodule

// File: rtl/segmap_table.sv
module segmap_table
    import segmap_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    // lookup read port
    input  logic [IDX_W-1:0] lk_idx,
    output logic [GSN_W-1:0] lk_tag,
    output perm_t            lk_perm,
    output logic [IDX_W-1:0] lk_id,
    // remap read ports
    input  logic [IDX_W-1:0] ra_idx,
    output perm_t            ra_perm,
    output logic [IDX_W-1:0] ra_id,
    input  logic [IDX_W-1:0] rb_idx,
    output logic [IDX_W-1:0] rb_id,
    // software write
    input  logic             os_we,
    input  logic [IDX_W-1:0] os_slot,
    input  logic [GSN_W-1:0] os_tag,
    input  perm_t            os_perm,
    // remap commit
    input  logic             cm_en,
    input  logic [IDX_W-1:0] cm_old,
    input  logic [IDX_W-1:0] cm_new,
    input  logic [GSN_W-1:0] cm_tag,
    input  perm_t            cm_perm,
    input  logic [IDX_W-1:0] cm_new_id,
    input  logic [IDX_W-1:0] cm_old_id
);

    localparam int DEPTH = 1 << IDX_W;

    logic [GSN_W-1:0] tag_q  [DEPTH];
    perm_t            perm_q [DEPTH];
    logic [IDX_W-1:0] id_q   [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst) begin
                tag_q[g]  <= '0;
                perm_q[g] <= '0;
                id_q[g]   <= IDX_W'(g);
            end else if (cm_en) begin
                if (cm_old == IDX_W'(g)) begin
                    id_q[g] <= cm_old_id;
                end
                // New-slot write comes last so a same-slot remap keeps its own id.
                if (cm_new == IDX_W'(g)) begin
                    tag_q[g]  <= cm_tag;
                    perm_q[g] <= cm_perm;
                    id_q[g]   <= cm_new_id;
                end
            end else if (os_we && (os_slot == IDX_W'(g))) begin
                tag_q[g]  <= os_tag;
                perm_q[g] <= os_perm;
            end
        end
    end

    always_comb begin
        lk_tag  = tag_q[lk_idx];
        lk_perm = perm_q[lk_idx];
        lk_id   = id_q[lk_idx];
        ra_perm = perm_q[ra_idx];
        ra_id   = id_q[ra_idx];
        rb_id   = id_q[rb_idx];
    end

endmodule

// File: rtl/segmap_remap_ctl.sv
module segmap_remap_ctl
    import segmap_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [IDX_W-1:0] old_slot,
    input  logic [GSN_W-1:0] new_gsn,
    input  perm_t            rd_old_perm,
    input  logic [IDX_W-1:0] rd_old_id,
    input  logic [IDX_W-1:0] rd_new_id,
    output logic             busy,
    output logic             commit,
    output logic [IDX_W-1:0] old_q,
    output logic [IDX_W-1:0] new_slot,
    output logic [GSN_W-1:0] gsn_q,
    output perm_t            perm_cap,
    output logic [IDX_W-1:0] old_id_cap,
    output logic [IDX_W-1:0] new_id_cap
);

    rm_state_e state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= RM_IDLE;
            old_q      <= '0;
            gsn_q      <= '0;
            perm_cap   <= '0;
            old_id_cap <= '0;
            new_id_cap <= '0;
        end else begin
            unique case (state_q)
                RM_IDLE: begin
                    if (start) begin
                        old_q   <= old_slot;
                        gsn_q   <= new_gsn;
                        state_q <= RM_READ;
                    end
                end
                RM_READ: begin
                    perm_cap   <= rd_old_perm;
                    old_id_cap <= rd_old_id;
                    new_id_cap <= rd_new_id;
                    state_q    <= RM_WRITE;
                end
                RM_WRITE: state_q <= RM_IDLE;
                default:  state_q <= RM_IDLE;
            endcase
        end
    end

    always_comb begin
        busy     = (state_q != RM_IDLE);
        commit   = (state_q == RM_WRITE);
        new_slot = gsn_q[IDX_W-1:0];
    end

endmodule

// File: rtl/segmap_probe.sv
module segmap_probe
    import segmap_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             accept,
    input  logic [GSN_W-1:0] gsn,
    input  perm_t            want,
    input  logic [GSN_W-1:0] ent_tag,
    input  perm_t            ent_perm,
    input  logic [IDX_W-1:0] ent_id,
    output logic             valid_q,
    output logic             hit_q,
    output logic             col_q,
    output logic             fault_q,
    output logic [IDX_W-1:0] id_q
);

    logic match;

    always_comb match = (ent_tag == gsn);

    always_ff @(posedge clk) begin
        if (rst || !accept) begin
            valid_q <= 1'b0;
            hit_q   <= 1'b0;
            col_q   <= 1'b0;
            fault_q <= 1'b0;
            id_q    <= '0;
        end else begin
            valid_q <= 1'b1;
            hit_q   <= match;
            col_q   <= !match;
            fault_q <= match && perm_denied(ent_perm, want);
            id_q    <= match ? ent_id : '0;
        end
    end

endmodule

// File: rtl/segmap_csr_unit.sv
module segmap_csr_unit
    import segmap_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [31:0]      req_vaddr,
    input  logic             req_rd,
    input  logic             req_wr,
    input  logic             req_ex,
    input  logic             req_sup,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic             rsp_collision,
    output logic             rsp_perm_fault,
    output logic [IDX_W-1:0] rsp_seg_id,
    input  logic             os_we,
    input  logic [IDX_W-1:0] os_slot,
    input  logic [12:0]      os_tag,
    input  logic [3:0]       os_perm,
    input  logic             rmp_start,
    input  logic [IDX_W-1:0] rmp_old_slot,
    input  logic [12:0]      rmp_new_gsn,
    output logic             rmp_busy
);

    logic [GSN_W-1:0] req_gsn;
    logic [IDX_W-1:0] req_idx;
    logic [GSN_W-1:0] ent_tag;
    perm_t            ent_perm;
    logic [IDX_W-1:0] ent_id;
    perm_t            rd_old_perm;
    logic [IDX_W-1:0] rd_old_id, rd_new_id;
    logic             busy, commit;
    logic [IDX_W-1:0] old_q, new_slot;
    logic [GSN_W-1:0] gsn_q;
    perm_t            perm_cap;
    logic [IDX_W-1:0] old_id_cap, new_id_cap;
    perm_t            want;
    logic             accept;
    logic             page_ofs_unused;

    always_comb begin
        want            = '{sup: req_sup, ex: req_ex, wr: req_wr, rd: req_rd};
        accept          = req_valid && !busy;
        page_ofs_unused = ^req_vaddr[SEG_LSB-1:0];
        rmp_busy        = busy;
    end

    segmap_gsn #(.IDX_W(IDX_W)) u_gsn (
        .asn (req_vaddr[ASN_LSB +: ASN_W]),
        .seg (req_vaddr[SEG_LSB +: SEG_W]),
        .gsn (req_gsn),
        .idx (req_idx)
    );

    segmap_table #(.IDX_W(IDX_W)) u_table (
        .clk       (clk),
        .rst       (rst),
        .lk_idx    (req_idx),
        .lk_tag    (ent_tag),
        .lk_perm   (ent_perm),
        .lk_id     (ent_id),
        .ra_idx    (old_q),
        .ra_perm   (rd_old_perm),
        .ra_id     (rd_old_id),
        .rb_idx    (new_slot),
        .rb_id     (rd_new_id),
        .os_we     (os_we && !busy),
        .os_slot   (os_slot),
        .os_tag    (os_tag),
        .os_perm   (perm_t'(os_perm)),
        .cm_en     (commit),
        .cm_old    (old_q),
        .cm_new    (new_slot),
        .cm_tag    (gsn_q),
        .cm_perm   (perm_cap),
        .cm_new_id (old_id_cap),
        .cm_old_id (new_id_cap)
    );

    segmap_remap_ctl #(.IDX_W(IDX_W)) u_remap (
        .clk         (clk),
        .rst         (rst),
        .start       (rmp_start),
        .old_slot    (rmp_old_slot),
        .new_gsn     (rmp_new_gsn),
        .rd_old_perm (rd_old_perm),
        .rd_old_id   (rd_old_id),
        .rd_new_id   (rd_new_id),
        .busy        (busy),
        .commit      (commit),
        .old_q       (old_q),
        .new_slot    (new_slot),
        .gsn_q       (gsn_q),
        .perm_cap    (perm_cap),
        .old_id_cap  (old_id_cap),
        .new_id_cap  (new_id_cap)
    );

    segmap_probe #(.IDX_W(IDX_W)) u_probe (
        .clk      (clk),
        .rst      (rst),
        .accept   (accept),
        .gsn      (req_gsn),
        .want     (want),
        .ent_tag  (ent_tag),
        .ent_perm (ent_perm),
        .ent_id   (ent_id),
        .valid_q  (rsp_valid),
        .hit_q    (rsp_hit),
        .col_q    (rsp_collision),
        .fault_q  (rsp_perm_fault),
        .id_q     (rsp_seg_id)
    );

endmodule

// File: rtl/segmap_chk.sv
module segmap_chk #(
    parameter int IDX_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic             rsp_valid,
    input logic             rsp_hit,
    input logic             rsp_collision,
    input logic             rsp_perm_fault,
    input logic [IDX_W-1:0] rsp_seg_id,
    input logic             rmp_start,
    input logic             rmp_busy
);

    logic past_ok;

    always_ff @(posedge clk) begin
        if (rst) past_ok <= 1'b0;
        else     past_ok <= 1'b1;
    end

    p_accept_answers_r3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !rmp_busy) |=> rsp_valid);

    p_answer_needs_accept_r3: assert property (@(posedge clk) disable iff (rst)
        (past_ok && rsp_valid) |-> $past(req_valid && !rmp_busy));

    p_idle_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid |-> !(rsp_hit || rsp_collision || rsp_perm_fault));

    p_hit_or_collision_r2: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_hit != rsp_collision));

    p_collision_wins_r5: assert property (@(posedge clk) disable iff (rst)
        rsp_collision |-> (!rsp_perm_fault && rsp_seg_id == '0));

    p_start_sets_busy_r9: assert property (@(posedge clk) disable iff (rst)
        (rmp_start && !rmp_busy) |=> rmp_busy);

    p_busy_two_cycles_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(rmp_busy) |=> rmp_busy ##1 !rmp_busy);

    p_busy_blocks_lookup_r9: assert property (@(posedge clk) disable iff (rst)
        rmp_busy |=> !rsp_valid);

endmodule

bind segmap_csr_unit segmap_chk #(.IDX_W(IDX_W)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .req_valid      (req_valid),
    .rsp_valid      (rsp_valid),
    .rsp_hit        (rsp_hit),
    .rsp_collision  (rsp_collision),
    .rsp_perm_fault (rsp_perm_fault),
    .rsp_seg_id     (rsp_seg_id),
    .rmp_start      (rmp_start),
    .rmp_busy       (rmp_busy)
);

// File: tb/sim_segmap_csr_unit.sv
module sim_segmap_csr_unit;

    localparam int CLK_PERIOD = 10;
    localparam int IDX_W      = 8;
    localparam int NVEC       = 11;

    // flags are {sup, ex, wr, rd}
    typedef struct packed {
        logic [31:0] va;
        logic [3:0]  flags;
        logic [3:0]  rq;
        logic        hit;
        logic        col;
        logic        pf;
        logic [7:0]  id;
    } vec_t;

    // R1 R2 R4 R5 R6 vectors, run after slots 0x24 and 0xE2 are loaded
    localparam vec_t VECS [NVEC] = '{
        '{32'h0110ABA5, 4'b0001, 4'd2, 1'b1, 1'b0, 1'b0, 8'h24},
        '{32'h0110ABA5, 4'b0010, 4'd4, 1'b1, 1'b0, 1'b0, 8'h24},
        '{32'h0110ABA5, 4'b0100, 4'd4, 1'b1, 1'b0, 1'b1, 8'h24},
        '{32'h091007FF, 4'b0100, 4'd5, 1'b0, 1'b1, 1'b0, 8'h00},
        '{32'h37880123, 4'b1001, 4'd1, 1'b1, 1'b0, 1'b0, 8'hE2},
        '{32'h37880123, 4'b0001, 4'd4, 1'b1, 1'b0, 1'b1, 8'hE2},
        '{32'h5A8807FF, 4'b1100, 4'd1, 1'b1, 1'b0, 1'b0, 8'hE2},
        '{32'hFF083C00, 4'b1010, 4'd1, 1'b1, 1'b0, 1'b1, 8'hE2},
        '{32'h00001234, 4'b0001, 4'd6, 1'b1, 1'b0, 1'b1, 8'h00},
        '{32'h00140000, 4'b0000, 4'd6, 1'b0, 1'b1, 1'b0, 8'h00},
        '{32'h0003FFFF, 4'b0000, 4'd4, 1'b1, 1'b0, 1'b0, 8'h00}
    };

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             req_valid = 1'b0;
    logic [31:0]      req_vaddr = '0;
    logic             req_rd = 1'b0, req_wr = 1'b0, req_ex = 1'b0, req_sup = 1'b0;
    logic             rsp_valid, rsp_hit, rsp_collision, rsp_perm_fault;
    logic [IDX_W-1:0] rsp_seg_id;
    logic             os_we = 1'b0;
    logic [IDX_W-1:0] os_slot = '0;
    logic [12:0]      os_tag = '0;
    logic [3:0]       os_perm = '0;
    logic             rmp_start = 1'b0;
    logic [IDX_W-1:0] rmp_old_slot = '0;
    logic [12:0]      rmp_new_gsn = '0;
    logic             rmp_busy;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    segmap_csr_unit #(.IDX_W(IDX_W)) u0 (.*);

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    function automatic logic [11:0] obs();
        return {rsp_valid, rsp_hit, rsp_collision, rsp_perm_fault, rsp_seg_id};
    endfunction

    function automatic logic [11:0] expect_rsp(input logic h, input logic c,
                                               input logic f, input logic [7:0] id);
        return {1'b1, h, c, f, id};
    endfunction

    task automatic os_write(input logic [7:0] slot, input logic [12:0] tag, input logic [3:0] pm);
        os_we = 1'b1; os_slot = slot; os_tag = tag; os_perm = pm;
        @(posedge clk); @(negedge clk);
        os_we = 1'b0;
    endtask

    task automatic lookup(input logic [31:0] va, input logic [3:0] fl, output logic [11:0] o);
        req_valid = 1'b1; req_vaddr = va;
        {req_sup, req_ex, req_wr, req_rd} = fl;
        @(posedge clk); @(negedge clk);
        req_valid = 1'b0;
        o = obs();
    endtask

    task automatic remap(input logic [7:0] old_slot, input logic [12:0] gsn);
        rmp_start = 1'b1; rmp_old_slot = old_slot; rmp_new_gsn = gsn;
        @(posedge clk); @(negedge clk);
        rmp_start = 1'b0;
        chk("R9 busy first cycle", 32'(rmp_busy), 32'd1);
        // blocked lookup, software write and second remap while busy
        req_valid = 1'b1; req_vaddr = 32'h0110ABA5;
        {req_sup, req_ex, req_wr, req_rd} = 4'b0001;
        os_we = 1'b1; os_slot = 8'h05; os_tag = 13'h005; os_perm = 4'hF;
        rmp_start = 1'b1; rmp_old_slot = 8'h05; rmp_new_gsn = 13'h006;
        @(posedge clk); @(negedge clk);
        req_valid = 1'b0; os_we = 1'b0; rmp_start = 1'b0;
        chk("R9 busy second cycle", 32'(rmp_busy), 32'd1);
        chk("R9 lookup ignored while busy", 32'(rsp_valid), 32'd0);
        @(posedge clk); @(negedge clk);
        chk("R9 busy released", 32'(rmp_busy), 32'd0);
        chk("R3 no response without accept", 32'(rsp_valid), 32'd0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R9 watchdog actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        logic [11:0] o;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R6 no response after reset", 32'(rsp_valid), 32'd0);
        chk("R6 idle after reset", 32'(rmp_busy), 32'd0);

        // R6 R7: reset identity of slot 0x9B, seen once a matching tag is stored
        os_write(8'h9B, 13'h09B, 4'b0001);
        lookup(32'h046C0000, 4'b0001, o);
        chk("R6 reset id equals slot", 32'(o), 32'(expect_rsp(1'b1, 1'b0, 1'b0, 8'h9B)));

        // Loads for the vector table
        os_write(8'h24, 13'h024, 4'b0011);
        os_write(8'hE2, 13'h1FE2, 4'b1101);

        for (int i = 0; i < NVEC; i++) begin
            lookup(VECS[i].va, VECS[i].flags, o);
            chk($sformatf("R%0d vector %0d", VECS[i].rq, i), 32'(o),
                32'(expect_rsp(VECS[i].hit, VECS[i].col, VECS[i].pf, VECS[i].id)));
        end

        // R3: an idle cycle yields no response
        @(posedge clk); @(negedge clk);
        chk("R3 idle cycle quiet", 32'(obs()), 32'd0);

        // R8: move the segment in slot 0x24 to global segment 0x060 (slot 0x60)
        remap(8'h24, 13'h060);
        lookup(32'h03000000, 4'b0011, o);
        chk("R8 new slot carries moved id and rights", 32'(o),
            32'(expect_rsp(1'b1, 1'b0, 1'b0, 8'h24)));
        lookup(32'h03000000, 4'b0100, o);
        chk("R8 copied rights deny execute", 32'(o),
            32'(expect_rsp(1'b1, 1'b0, 1'b1, 8'h24)));
        lookup(32'h0110ABA5, 4'b0001, o);
        chk("R8 old slot takes swapped id", 32'(o),
            32'(expect_rsp(1'b1, 1'b0, 1'b0, 8'h60)));
        lookup(32'h00140000, 4'b0001, o);
        chk("R9 software write ignored while busy", 32'(o),
            32'(expect_rsp(1'b0, 1'b1, 1'b0, 8'h00)));
        lookup(32'h00180000, 4'b0001, o);
        chk("R9 second remap ignored while busy", 32'(o),
            32'(expect_rsp(1'b0, 1'b1, 1'b0, 8'h00)));

        // R10: same-slot remap retags slot 0xE2 and keeps its id
        remap(8'hE2, 13'h0E2);
        lookup(32'h07080000, 4'b1001, o);
        chk("R10 retag keeps id", 32'(o), 32'(expect_rsp(1'b1, 1'b0, 1'b0, 8'hE2)));
        lookup(32'h37880123, 4'b1001, o);
        chk("R10 old tag now collides", 32'(o), 32'(expect_rsp(1'b0, 1'b1, 1'b0, 8'h00)));

        // R7: software rewrite of slot 0x60 keeps the swapped id
        os_write(8'h60, 13'h060, 4'b0100);
        lookup(32'h03000000, 4'b0100, o);
        chk("R7 write keeps id", 32'(o), 32'(expect_rsp(1'b1, 1'b0, 1'b0, 8'h24)));
        lookup(32'h03000000, 4'b0001, o);
        chk("R7 new rights apply", 32'(o), 32'(expect_rsp(1'b1, 1'b0, 1'b1, 8'h24)));

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule